// File: doc/BRIEF.md
# Packet Queue Interrupt Generator

This block keeps three short queues of packet numbers for a network controller and turns their occupancy into interrupt status. The receive queue holds packets that have arrived and wait for the host. The transmit queue holds packets that the host has queued for sending. The completion queue holds the outcome of packets that have been sent. Every interrupt source is a level condition on queue state, not a pulse. The host can drain as many queue entries as it likes inside one service routine, and no register read is needed before the controller moves on to the next packet.

Each queue has its own push and pop ports and shows its oldest entry at a head output. A mask register gates the status bits. A single registered interrupt line is raised when any unmasked status bit is set. When auto-release is on, a successful transmit is not queued for the host. Its packet number is sent out on a release port for one cycle instead, so the page can go back to the allocator. This option, together with the choice of which transmit status bits are unmasked, lets the host take either one interrupt per sent packet or one interrupt per burst of packets.

Top module: `pktq_irq_gen`

## Requirements
- R1: After reset all queues are empty, the mask is 0, `irq` is 0, `release_valid` is 0, and `status` is 4'b0100.
- R2: Each queue returns packet numbers in the order they were pushed, and its head output always shows the oldest entry.
- R3: A queue holds 8 entries. A push to a full queue is dropped and leaves the contents unchanged. It also sets `status[3]`, a sticky overflow bit that only reset clears. A pop of an empty queue is ignored.
- R4: `status[0]` is 1 exactly when the receive queue is not empty. It updates in the cycle after the push or pop edge.
- R5: `status[1]` is 1 exactly when the completion queue is not empty.
- R6: `status[2]` is 1 exactly when the transmit queue is empty and `tx_busy` is low.
- R7: `irq` is registered. It equals the OR of (`status` AND mask) as sampled at the previous clock edge.
- R8: A cycle with `mask_wr` high loads `mask_din` into the mask, and `int_mask` shows the mask.
- R9: A completion (`done_valid`) that has `done_ok` high while `auto_release` is high is not queued. Instead `release_valid` goes high for exactly one cycle after that edge, with `release_pkt` equal to `done_pkt`.
- R10: Any other completion pushes {`done_ok`, `done_pkt`} into the completion queue (`cmp_head_ok`, `cmp_head`). No release pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Push into the receive queue |
| rx_pkt_in | input | 4 | Packet number to push into the receive queue |
| rx_pop | input | 1 | Host removes the receive head |
| rx_head | output | 4 | Oldest receive packet number |
| tx_push | input | 1 | Host queues a packet for transmit |
| tx_pkt_in | input | 4 | Packet number to transmit |
| tx_pop | input | 1 | Transmitter takes the transmit head |
| tx_head | output | 4 | Next packet number to transmit |
| tx_busy | input | 1 | A transmission is still in progress |
| done_valid | input | 1 | Transmit completion event |
| done_pkt | input | 4 | Packet number of the completed transmit |
| done_ok | input | 1 | Completed transmit succeeded |
| auto_release | input | 1 | Release successful transmits instead of queuing them |
| cmp_pop | input | 1 | Host removes the completion head |
| cmp_head | output | 4 | Oldest completion packet number |
| cmp_head_ok | output | 1 | Success flag of the oldest completion |
| release_valid | output | 1 | One-cycle page release strobe |
| release_pkt | output | 4 | Packet number being released |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_din | input | 4 | New interrupt mask |
| int_mask | output | 4 | Current interrupt mask |
| status | output | 4 | {overflow, tx-empty, tx-complete, rx-ready} |
| irq | output | 1 | Registered interrupt request |

## Verification
Some properties are checked on every cycle. Occupancy never goes past the depth, and a push to a full queue with no pop leaves the count unchanged. The overflow bit never clears once set. `irq` lags the masked status by one edge. The transmit-empty bit stays low while `tx_busy` is high. A release strobe only follows a successful completion made with auto-release on. Some behaviours can only be shown by the bench scenarios: first-in-first-out order through each queue, dropping the ninth push, ignoring a pop of an empty queue, and routing completions between the release port and the completion queue.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
   localparam int ST_RX  = 0;
   localparam int ST_TXC = 1;
   localparam int ST_TXE = 2;
   localparam int ST_OVF = 3;
   localparam int ST_W   = 4;
endpackage

// File: rtl/pktq_fifo.sv
module pktq_fifo #(
   parameter int W     = 4,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         drop
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pktq_fifo: DEPTH must be a power of two, at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pktq_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          push_acc, pop_acc;

   assign empty    = (count == '0);
   assign full     = (count == CW'(DEPTH));
   assign pop_acc  = pop && !empty;
   assign push_acc = push && (!full || pop_acc);
   assign drop     = push && !push_acc;
   assign dout     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_acc) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_acc) wr_ptr <= wr_ptr + 1'b1;
         if (pop_acc)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_acc, pop_acc})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3: occupancy bounded by depth
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R3: push into a full queue without a pop changes nothing
   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/pktq_irq_ctl.sv
module pktq_irq_ctl #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] status,
   input  logic            mask_wr,
   input  logic [NSRC-1:0] mask_din,
   output logic [NSRC-1:0] mask,
   output logic            irq
);
   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("pktq_irq_ctl: NSRC must be positive");
      end
   endgenerate

   logic [NSRC-1:0] pend;
   assign pend = status & mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '0;
         irq  <= 1'b0;
      end else begin
         if (mask_wr) mask <= mask_din;
         irq <= |pend;
      end
   end

   // R7: interrupt follows masked status one edge later
   p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(status & mask)));
   // R8: mask load takes effect after the write edge
   p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask == $past(mask_din)));
endmodule

// File: rtl/pktq_irq_gen.sv
module pktq_irq_gen
   import pktq_pkg::*;
#(
   parameter int PKT_W = 4,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_push,
   input  logic [PKT_W-1:0] rx_pkt_in,
   input  logic             rx_pop,
   output logic [PKT_W-1:0] rx_head,
   input  logic             tx_push,
   input  logic [PKT_W-1:0] tx_pkt_in,
   input  logic             tx_pop,
   output logic [PKT_W-1:0] tx_head,
   input  logic             tx_busy,
   input  logic             done_valid,
   input  logic [PKT_W-1:0] done_pkt,
   input  logic             done_ok,
   input  logic             auto_release,
   input  logic             cmp_pop,
   output logic [PKT_W-1:0] cmp_head,
   output logic             cmp_head_ok,
   output logic             release_valid,
   output logic [PKT_W-1:0] release_pkt,
   input  logic             mask_wr,
   input  logic [ST_W-1:0]  mask_din,
   output logic [ST_W-1:0]  int_mask,
   output logic [ST_W-1:0]  status,
   output logic             irq
);
   localparam int CMP_W = PKT_W + 1;

   logic rx_empty, rx_full, rx_drop;
   logic tx_empty, tx_full, tx_drop;
   logic cq_empty, cq_full, cq_drop;
   logic release_now, cq_push, ovf_q;
   logic [CMP_W-1:0] cq_dout;

   pktq_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_pkt_in), .pop(rx_pop),
      .dout(rx_head), .empty(rx_empty), .full(rx_full), .drop(rx_drop));

   pktq_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_pkt_in), .pop(tx_pop),
      .dout(tx_head), .empty(tx_empty), .full(tx_full), .drop(tx_drop));

   assign release_now = done_valid && done_ok && auto_release;
   assign cq_push     = done_valid && !release_now;

   pktq_fifo #(.W(CMP_W), .DEPTH(DEPTH)) u_cmpq (
      .clk(clk), .rst_n(rst_n), .push(cq_push), .din({done_ok, done_pkt}),
      .pop(cmp_pop), .dout(cq_dout), .empty(cq_empty), .full(cq_full),
      .drop(cq_drop));

   assign cmp_head    = cq_dout[PKT_W-1:0];
   assign cmp_head_ok = cq_dout[PKT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         release_valid <= 1'b0;
         release_pkt   <= '0;
         ovf_q         <= 1'b0;
      end else begin
         release_valid <= release_now;
         if (release_now) release_pkt <= done_pkt;
         if (rx_drop || tx_drop || cq_drop) ovf_q <= 1'b1;
      end
   end

   always_comb begin
      status         = '0;
      status[ST_RX]  = !rx_empty;
      status[ST_TXC] = !cq_empty;
      status[ST_TXE] = tx_empty && !tx_busy;
      status[ST_OVF] = ovf_q;
   end

   pktq_irq_ctl #(.NSRC(ST_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .status(status), .mask_wr(mask_wr),
      .mask_din(mask_din), .mask(int_mask), .irq(irq));

   // R3: overflow is sticky
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(status[ST_OVF]) |-> status[ST_OVF]);
   // R4: receive-ready can only rise after a receive push
   p_rx_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_RX]) |-> $past(rx_push));
   // R6: no transmit-empty while a transmission runs
   p_txe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !status[ST_TXE]);
   // R9: release strobe only after a successful auto-released completion
   p_release_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      release_valid |-> $past(done_valid && done_ok && auto_release));
   // R10: a queued completion never produces a release strobe
   p_no_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !(done_ok && auto_release)) |=> !release_valid);
endmodule

// File: tb/tb_pktq_irq_gen.sv
module tb_pktq_irq_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, tx_busy = 0;
   logic done_valid = 0, done_ok = 0, auto_release = 0, cmp_pop = 0, mask_wr = 0;
   logic [3:0] rx_pkt_in = 0, tx_pkt_in = 0, done_pkt = 0, mask_din = 0;
   logic [3:0] rx_head, tx_head, cmp_head, release_pkt, int_mask, status;
   logic cmp_head_ok, release_valid, irq;

   int tests = 0, fails = 0;
   bit finished = 0;
   logic [3:0] rx_m[$];
   logic [3:0] tx_m[$];
   logic [4:0] cq_m[$];

   always #2 clk = ~clk;

   pktq_irq_gen dut (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pkt_in(rx_pkt_in),
      .rx_pop(rx_pop), .rx_head(rx_head), .tx_push(tx_push), .tx_pkt_in(tx_pkt_in),
      .tx_pop(tx_pop), .tx_head(tx_head), .tx_busy(tx_busy), .done_valid(done_valid),
      .done_pkt(done_pkt), .done_ok(done_ok), .auto_release(auto_release),
      .cmp_pop(cmp_pop), .cmp_head(cmp_head), .cmp_head_ok(cmp_head_ok),
      .release_valid(release_valid), .release_pkt(release_pkt), .mask_wr(mask_wr),
      .mask_din(mask_din), .int_mask(int_mask), .status(status), .irq(irq));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver side: stimulus plus expected-item scoreboard
   task automatic push_rx(logic [3:0] p);
      rx_push = 1; rx_pkt_in = p; step(); rx_push = 0;
      if (rx_m.size() < 8) rx_m.push_back(p);
   endtask
   task automatic push_tx(logic [3:0] p);
      tx_push = 1; tx_pkt_in = p; step(); tx_push = 0;
      if (tx_m.size() < 8) tx_m.push_back(p);
   endtask
   task automatic complete(logic [3:0] p, logic ok);
      done_valid = 1; done_pkt = p; done_ok = ok; step(); done_valid = 0;
      if (!(ok && auto_release)) cq_m.push_back({ok, p});
   endtask
   task automatic write_mask(logic [3:0] m);
      mask_wr = 1; mask_din = m; step(); mask_wr = 0;
   endtask

   // monitor side: compare heads with the scoreboard, then pop
   task automatic pop_rx(string req);
      logic [3:0] e = rx_m.pop_front();
      check(req, rx_head, e);
      rx_pop = 1; step(); rx_pop = 0;
   endtask
   task automatic pop_tx(string req);
      logic [3:0] e = tx_m.pop_front();
      check(req, tx_head, e);
      tx_pop = 1; step(); tx_pop = 0;
   endtask
   task automatic pop_cmp(string req);
      logic [4:0] e = cq_m.pop_front();
      check(req, {cmp_head_ok, cmp_head}, e);
      cmp_pop = 1; step(); cmp_pop = 0;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1;
      step();
      // R1 reset state
      check("R1 status", status, 4'b0100);
      check("R1 irq", irq, 0);
      check("R1 mask", int_mask, 0);
      check("R1 release", release_valid, 0);

      // R8 / R7 mask and registered interrupt
      write_mask(4'b0100);
      check("R8 mask load", int_mask, 4'b0100);
      check("R7 irq lag", irq, 0);
      step();
      check("R7 irq on tx-empty", irq, 1);
      write_mask(4'b0001);
      check("R7 irq still old mask", irq, 1);
      step();
      check("R7 irq drops", irq, 0);

      // R4 / R2 receive queue
      push_rx(4'd5);
      check("R4 rx status", status[0], 1);
      push_rx(4'd9);
      push_rx(4'd2);
      check("R7 rx irq", irq, 1);
      for (int i = 0; i < 3; i++) pop_rx("R2 rx order");
      check("R4 rx status clear", status[0], 0);
      step();
      check("R7 irq clear", irq, 0);

      // R3 overflow
      check("R3 ovf before", status[3], 0);
      for (int i = 1; i <= 9; i++) push_rx(4'(i));
      check("R3 ovf sticky set", status[3], 1);
      for (int i = 0; i < 8; i++) pop_rx("R3 full contents");
      rx_pop = 1; step(); rx_pop = 0;
      check("R3 pop empty", status[0], 0);
      push_rx(4'd12);
      pop_rx("R3 after empty pop");
      check("R3 ovf stays", status[3], 1);

      // R6 transmit empty gated by busy
      push_tx(4'd3);
      push_tx(4'd6);
      check("R6 tx not empty", status[2], 0);
      tx_busy = 1;
      pop_tx("R2 tx order");
      pop_tx("R2 tx order");
      check("R6 busy holds off", status[2], 0);
      tx_busy = 0;
      #1;
      check("R6 empty idle", status[2], 1);

      // R10 / R5 / R9 completion routing
      write_mask(4'b0010);
      complete(4'd7, 1);
      check("R10 no release", release_valid, 0);
      check("R5 cmp status", status[1], 1);
      step();
      check("R7 cmp irq", irq, 1);
      auto_release = 1;
      complete(4'd3, 1);
      check("R9 release strobe", release_valid, 1);
      check("R9 release pkt", release_pkt, 3);
      step();
      check("R9 one cycle", release_valid, 0);
      complete(4'd4, 0);
      check("R10 failed no release", release_valid, 0);
      pop_cmp("R9 skipped queue");
      pop_cmp("R10 failed queued");
      check("R5 cmp status clear", status[1], 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule